// File: doc/BRIEF.md
# SMI status and enable aggregator

This block holds the 32-bit status word that gathers every system-management interrupt cause in a power-management unit, together with its companion 32-bit enable word, and drives one active-low SMI# line. Some status positions are sticky flags that software clears by writing a one to them. Others are non-sticky views that follow their source every cycle, including two summaries that are each the OR of (status AND enable) over a USB sub-register group. A set of summary positions carries no enable and asserts SMI# on its own.

One sticky flag is the SMBus cause. It is qualified from four slow-domain conditions (about 64 kHz) and passes through a synchroniser with rising-edge detection. After the flag is set, a clear is refused for a programmable hold-off window, so software cannot clear it before one slow-clock period has passed. The periodic-rate generator, the trap decoder and the USB sub-register contents are outside the block and arrive as inputs.

Top module: `smi_agg`

## Requirements
- R1: After reset, the status word and the enable word both read 00000000h and smi_n is high.
- R2: A read with bus_addr = 34h returns the status word. A read at 30h returns the enable word. A read at any other address returns 0. Only bits 13, 14, 15, 16, 17, 18, 20 and 21 of the enable word can be written; all its other bits read 0.
- R3: Status bits 13 (watchdog-timer cause), 14 (periodic tick) and 16 (SMBus cause) are cleared by writing 1 to them at 34h. Writing 0 to them has no effect.
- R4: If a set event and a write-one-to-clear reach bit 13 or bit 14 in the same cycle, the bit ends up set.
- R5: Status bits 15 (serial-IRQ request), 20 (PCI Express event) and 21 (trap hit) follow their inputs one cycle later. They are not sticky, and writes to them are ignored.
- R6: Status bit 17 equals the OR over group A of (status AND enable), and bit 18 does the same for group B. Each reads 0 when its group has no enable set, and writes to these bits are ignored.
- R7: Status bits 8, 9, 10 and 12 follow free_sum[0..3], one cycle later. Any one of them set drives smi_n low, whatever the enable word holds.
- R8: smi_n is low when any status bit among 13–18, 20 and 21 is set together with the enable bit at the same position. A periodic tick sets bit 14 but drives smi_n low only while enable bit 14 is set.
- R9: The SMBus cause is raised by any of four conditions: a slave SMI message; the alert input while SMBus-SMI is enabled and alert is not masked; a host-notify message while both notify-interrupt and SMBus-SMI are enabled; a link-slave SMI command while the system is in S0. Any other combination leaves bit 16 clear.
- R10: The SMBus request passes through a two-stage synchroniser and an edge detector. Bit 16 reads set three clock edges after the request rises and not before. A request held high sets the bit only once.
- R11: For HOLD_CYC cycles after bit 16 is set, a write-one-to-clear on it is ignored. After that window, the same write clears it.
- R12: Reserved status bits (0–7, 11, 19, 22–31) read 0 and ignore writes.
- R13: smi_n is a level output. It returns high only once every enabled status bit and every enable-free summary bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |
| wdt_evt | input | 1 | Watchdog-timer SMI event pulse |
| per_tick | input | 1 | Periodic-rate tick |
| sirq_req | input | 1 | Serial-IRQ decoder SMI request level |
| pcie_evt | input | 1 | PCI Express PME / hot-plug SMI level |
| trap_hit | input | 1 | Trap/monitor access hit level |
| free_sum | input | 4 | Enable-free summary levels for bits 8, 9, 10, 12 |
| usb_a_sts | input | USB_A_W | USB group A sub-register status |
| usb_a_en | input | USB_A_W | USB group A sub-register enables |
| usb_b_sts | input | USB_B_W | USB group B sub-register status |
| usb_b_en | input | USB_B_W | USB group B sub-register enables |
| smb_slv_msg | input | 1 | Slow domain: slave SMI message received |
| smb_alert_act | input | 1 | Slow domain: alert input active |
| smb_smi_ena | input | 1 | SMBus SMI enable |
| smb_alert_off | input | 1 | Alert mask |
| smb_notify_msg | input | 1 | Slow domain: host-notify message received |
| smb_notify_ena | input | 1 | Host-notify interrupt enable |
| smb_link_cmd | input | 1 | Slow domain: link-slave SMI command |
| sys_in_s0 | input | 1 | System is in working state S0 |
| smi_n | output | 1 | Active-low SMI output |

## Verification
Two pairs of functions can fall in the same cycle. A source event can meet a write-one-to-clear on the same sticky bit, and a software clear can meet the SMBus hold-off window. The bench provokes the first by raising the watchdog event in the very cycle of a clearing write, then reads bit 13 back and expects it set. It provokes the second by writing the clear on the edge right after the synchronised set, expecting the bit to survive, and then repeating the write after the window, expecting it to clear.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
    localparam int REG_W  = 32;
    localparam int B_WDT  = 13;
    localparam int B_PER  = 14;
    localparam int B_SIRQ = 15;
    localparam int B_SMB  = 16;
    localparam int B_USBA = 17;
    localparam int B_USBB = 18;
    localparam int B_PCIE = 20;
    localparam int B_TRAP = 21;

    // positions that can be enabled, that clear on write-one, that need no enable
    localparam logic [REG_W-1:0] EN_MASK   = 32'h0037_E000;
    localparam logic [REG_W-1:0] W1C_MASK  = 32'h0001_6000;
    localparam logic [REG_W-1:0] FREE_MASK = 32'h0000_1700;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
    } agg_st_t;
endpackage

// File: rtl/smi_smb_qual.sv
module smi_smb_qual (
    input  logic slv_msg,
    input  logic alert_act,
    input  logic smi_ena,
    input  logic alert_off,
    input  logic notify_msg,
    input  logic notify_ena,
    input  logic link_cmd,
    input  logic in_s0,
    output logic req
);
    logic alert_ok, notify_ok, link_ok;

    always_comb begin
        alert_ok  = alert_act & smi_ena & ~alert_off;
        notify_ok = notify_msg & notify_ena & smi_ena;
        link_ok   = link_cmd & in_s0;
        req       = slv_msg | alert_ok | notify_ok | link_ok;
    end
endmodule

// File: rtl/smi_slow_sync.sv
module smi_slow_sync #(
    parameter int SYNC_STG = 2,
    parameter int HOLD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic set_pls,
    output logic hold_act
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [SYNC_STG-1:0] chain;
        logic                prev;
        logic [CNT_W-1:0]    cnt;
    } sync_st_t;

    sync_st_t sy_d, sy_q;

    always_comb begin
        sy_d          = sy_q;
        sy_d.chain[0] = req_async;
        for (int i = 1; i < SYNC_STG; i++) begin
            sy_d.chain[i] = sy_q.chain[i-1];
        end
        sy_d.prev = sy_q.chain[SYNC_STG-1];
        set_pls   = sy_q.chain[SYNC_STG-1] & ~sy_q.prev;
        hold_act  = (sy_q.cnt != '0);
        if (set_pls) begin
            sy_d.cnt = CNT_W'(HOLD_CYC);
        end else if (hold_act) begin
            sy_d.cnt = sy_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_pls |=> !set_pls); // R10
    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        set_pls |=> hold_act); // R11
endmodule

// File: rtl/smi_grp_sum.sv
module smi_grp_sum #(
    parameter int W = 8
) (
    input  logic [W-1:0] sts,
    input  logic [W-1:0] en,
    output logic         hit
);
    logic [W-1:0] both;

    for (genvar g = 0; g < W; g++) begin : g_and
        assign both[g] = sts[g] & en[g];
    end

    assign hit = |both;
endmodule

// File: rtl/smi_agg.sv
module smi_agg
    import smi_agg_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STS_OFS = 8'h34,
    parameter logic [ADDR_W-1:0] EN_OFS  = 8'h30,
    parameter int              USB_A_W  = 8,
    parameter int              USB_B_W  = 6,
    parameter int              SYNC_STG = 2,
    parameter int              HOLD_CYC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               wdt_evt,
    input  logic               per_tick,
    input  logic               sirq_req,
    input  logic               pcie_evt,
    input  logic               trap_hit,
    input  logic [3:0]         free_sum,
    input  logic [USB_A_W-1:0] usb_a_sts,
    input  logic [USB_A_W-1:0] usb_a_en,
    input  logic [USB_B_W-1:0] usb_b_sts,
    input  logic [USB_B_W-1:0] usb_b_en,
    input  logic               smb_slv_msg,
    input  logic               smb_alert_act,
    input  logic               smb_smi_ena,
    input  logic               smb_alert_off,
    input  logic               smb_notify_msg,
    input  logic               smb_notify_ena,
    input  logic               smb_link_cmd,
    input  logic               sys_in_s0,
    output logic               smi_n
);
    agg_st_t st_d, st_q;

    logic smb_req, smb_set, smb_hold;
    logic usb_a_hit, usb_b_hit;
    logic wr_sts, wr_en;
    logic enabled_hit, free_hit;

    smi_smb_qual u_qual (
        .slv_msg    (smb_slv_msg),
        .alert_act  (smb_alert_act),
        .smi_ena    (smb_smi_ena),
        .alert_off  (smb_alert_off),
        .notify_msg (smb_notify_msg),
        .notify_ena (smb_notify_ena),
        .link_cmd   (smb_link_cmd),
        .in_s0      (sys_in_s0),
        .req        (smb_req)
    );

    smi_slow_sync #(.SYNC_STG(SYNC_STG), .HOLD_CYC(HOLD_CYC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (smb_req),
        .set_pls   (smb_set),
        .hold_act  (smb_hold)
    );

    smi_grp_sum #(.W(USB_A_W)) u_sum_a (.sts(usb_a_sts), .en(usb_a_en), .hit(usb_a_hit));
    smi_grp_sum #(.W(USB_B_W)) u_sum_b (.sts(usb_b_sts), .en(usb_b_en), .hit(usb_b_hit));

    always_comb begin
        wr_sts = bus_wr && (bus_addr == STS_OFS);
        wr_en  = bus_wr && (bus_addr == EN_OFS);

        st_d.en = st_q.en;
        if (wr_en) begin
            st_d.en = bus_wdata & EN_MASK;
        end

        st_d.sts = '0;
        // sticky flags: a set event beats a same-cycle clear
        st_d.sts[B_WDT] = wdt_evt  | (st_q.sts[B_WDT] & ~(wr_sts & bus_wdata[B_WDT]));
        st_d.sts[B_PER] = per_tick | (st_q.sts[B_PER] & ~(wr_sts & bus_wdata[B_PER]));
        st_d.sts[B_SMB] = smb_set  |
                          (st_q.sts[B_SMB] & ~(wr_sts & bus_wdata[B_SMB] & ~smb_hold));
        // non-sticky views
        st_d.sts[B_SIRQ] = sirq_req;
        st_d.sts[B_USBA] = usb_a_hit;
        st_d.sts[B_USBB] = usb_b_hit;
        st_d.sts[B_PCIE] = pcie_evt;
        st_d.sts[B_TRAP] = trap_hit;
        // enable-free summaries
        st_d.sts[8]  = free_sum[0];
        st_d.sts[9]  = free_sum[1];
        st_d.sts[10] = free_sum[2];
        st_d.sts[12] = free_sum[3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        enabled_hit = |(st_q.sts & st_q.en & EN_MASK);
        free_hit    = |(st_q.sts & FREE_MASK);
        smi_n       = ~(enabled_hit | free_hit);
        bus_rdata   = '0;
        if (bus_rd) begin
            if (bus_addr == STS_OFS) begin
                bus_rdata = st_q.sts;
            end else if (bus_addr == EN_OFS) begin
                bus_rdata = st_q.en;
            end
        end
    end

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && bus_wdata[B_PER] && !per_tick) |=> !st_q.sts[B_PER]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_evt |=> st_q.sts[B_WDT]); // R4
    AST_SMB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smb_hold && st_q.sts[B_SMB]) |=> st_q.sts[B_SMB]); // R11
    AST_FREE_SMI: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts[8] || st_q.sts[12]) |-> !smi_n); // R7
    AST_USB_NOEN: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_a_en == '0) |=> !st_q.sts[B_USBA]); // R6
    AST_PER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts[B_PER] && st_q.en[B_PER]) |-> !smi_n); // R8
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ((bus_rdata & ~(EN_MASK | FREE_MASK)) == '0)); // R12
endmodule

// File: tb/sim_smi_agg.sv
module sim_smi_agg;
    localparam int CLK_NS = 10;
    localparam int HOLD   = 12;
    localparam logic [7:0] A_STS = 8'h34;
    localparam logic [7:0] A_EN  = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_evt = 0, per_tick = 0, sirq_req = 0, pcie_evt = 0, trap_hit = 0;
    logic [3:0]  free_sum = '0;
    logic [7:0]  usb_a_sts = '0, usb_a_en = '0;
    logic [5:0]  usb_b_sts = '0, usb_b_en = '0;
    logic        smb_slv_msg = 0, smb_alert_act = 0, smb_smi_ena = 0, smb_alert_off = 0;
    logic        smb_notify_msg = 0, smb_notify_ena = 0, smb_link_cmd = 0, sys_in_s0 = 0;
    logic        smi_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    smi_agg #(.HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_evt(wdt_evt), .per_tick(per_tick),
        .sirq_req(sirq_req), .pcie_evt(pcie_evt), .trap_hit(trap_hit), .free_sum(free_sum),
        .usb_a_sts(usb_a_sts), .usb_a_en(usb_a_en), .usb_b_sts(usb_b_sts), .usb_b_en(usb_b_en),
        .smb_slv_msg(smb_slv_msg), .smb_alert_act(smb_alert_act), .smb_smi_ena(smb_smi_ena),
        .smb_alert_off(smb_alert_off), .smb_notify_msg(smb_notify_msg),
        .smb_notify_ena(smb_notify_ena), .smb_link_cmd(smb_link_cmd), .sys_in_s0(sys_in_s0),
        .smi_n(smi_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns without consuming a cycle
    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        v        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    // called just after a falling edge; write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STS, v); chk("R1 status after reset", v, 32'h0);
        rd(A_EN, v);  chk("R1 enable after reset", v, 32'h0);
        chk("R1 smi_n after reset", {31'h0, smi_n}, 32'h1);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v);   chk("R2 enable writable mask", v, 32'h0037_E000);
        rd(8'h38, v);  chk("R2 unmapped address reads 0", v, 32'h0);
        wr(A_EN, 32'h0);
        wr(A_STS, 32'hFFC8_0EFF);
        rd(A_STS, v);  chk("R12 reserved bits ignore writes", v, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wdt_evt = 1; @(negedge clk); wdt_evt = 0;
        rd(A_STS, v); chk("R3 watchdog bit set", v, 32'h0000_2000);
        chk("R8 no SMI without enable", {31'h0, smi_n}, 32'h1);
        wr(A_STS, 32'h0);
        rd(A_STS, v); chk("R3 write 0 keeps bit", v, 32'h0000_2000);
        wr(A_STS, 32'h0000_2000);
        rd(A_STS, v); chk("R3 write 1 clears bit", v, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        per_tick = 1; @(negedge clk); per_tick = 0;
        rd(A_STS, v); chk("R8 periodic bit set", v, 32'h0000_4000);
        chk("R8 periodic without enable no SMI", {31'h0, smi_n}, 32'h1);
        wr(A_EN, 32'h0000_4000);
        chk("R8 periodic with enable asserts SMI", {31'h0, smi_n}, 32'h0);
        wr(A_STS, 32'h0000_4000);
        chk("R13 SMI releases after clear", {31'h0, smi_n}, 32'h1);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wdt_evt = 1;
        wr(A_STS, 32'h0000_2000);
        wdt_evt = 0;
        rd(A_STS, v); chk("R4 set beats same-cycle clear", v, 32'h0000_2000);
        wr(A_STS, 32'h0000_2000);
        rd(A_STS, v); chk("R4 later clear works", v, 32'h0);
    endtask

    task automatic t_nonsticky();
        logic [31:0] v;
        sirq_req = 1; pcie_evt = 1; trap_hit = 1;
        @(negedge clk);
        rd(A_STS, v); chk("R5 levels reflected", v, 32'h0030_8000);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, v); chk("R5 writes ignored", v, 32'h0030_8000);
        sirq_req = 0; pcie_evt = 0; trap_hit = 0;
        @(negedge clk);
        rd(A_STS, v); chk("R5 not sticky", v, 32'h0);
    endtask

    task automatic t_usb();
        logic [31:0] v;
        usb_a_sts = 8'hFF; usb_a_en = 8'h00;
        @(negedge clk);
        rd(A_STS, v); chk("R6 group A no enables reads 0", v, 32'h0);
        usb_a_en = 8'h10; usb_b_sts = 6'h01; usb_b_en = 6'h01;
        @(negedge clk);
        rd(A_STS, v); chk("R6 both summaries set", v, 32'h0006_0000);
        wr(A_EN, 32'h0002_0000);
        chk("R8 summary with enable asserts SMI", {31'h0, smi_n}, 32'h0);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, v); chk("R6 summary writes ignored", v, 32'h0006_0000);
        usb_a_sts = 8'h0F;
        @(negedge clk);
        rd(A_STS, v); chk("R6 group A follows AND", v, 32'h0004_0000);
        chk("R13 SMI drops once enabled source clears", {31'h0, smi_n}, 32'h1);
        usb_a_sts = '0; usb_a_en = '0; usb_b_sts = '0; usb_b_en = '0;
        wr(A_EN, 32'h0);
    endtask

    task automatic t_free();
        logic [31:0] v;
        free_sum = 4'b0100;
        @(negedge clk);
        rd(A_STS, v); chk("R7 free bit 10 set", v, 32'h0000_0400);
        chk("R7 free bit asserts SMI with no enable", {31'h0, smi_n}, 32'h0);
        free_sum = 4'b1000;
        @(negedge clk);
        rd(A_STS, v); chk("R7 free bit 12 set", v, 32'h0000_1000);
        free_sum = 4'b0000;
        @(negedge clk);
        chk("R13 SMI high after free bits drop", {31'h0, smi_n}, 32'h1);
    endtask

    task automatic smb_clear_all();
        smb_slv_msg = 0; smb_alert_act = 0; smb_smi_ena = 0; smb_alert_off = 0;
        smb_notify_msg = 0; smb_notify_ena = 0; smb_link_cmd = 0; sys_in_s0 = 0;
        idle(HOLD + 4);
        wr(A_STS, 32'h0001_0000);
        idle(2);
    endtask

    task automatic smb_probe(input string tag, input logic exp_set);
        logic [31:0] v;
        idle(5);
        rd(A_STS, v);
        chk(tag, v, exp_set ? 32'h0001_0000 : 32'h0);
        smb_clear_all();
    endtask

    task automatic t_smb_qual();
        smb_slv_msg = 1;                                   smb_probe("R9 slave message", 1);
        smb_alert_act = 1; smb_smi_ena = 1;                smb_probe("R9 alert enabled", 1);
        smb_alert_act = 1; smb_smi_ena = 0;                smb_probe("R9 alert without SMI enable", 0);
        smb_alert_act = 1; smb_smi_ena = 1; smb_alert_off = 1; smb_probe("R9 alert masked", 0);
        smb_notify_msg = 1; smb_notify_ena = 1; smb_smi_ena = 1; smb_probe("R9 notify enabled", 1);
        smb_notify_msg = 1; smb_smi_ena = 1;               smb_probe("R9 notify without enable", 0);
        smb_link_cmd = 1; sys_in_s0 = 1;                   smb_probe("R9 link command in S0", 1);
        smb_link_cmd = 1; sys_in_s0 = 0;                   smb_probe("R9 link command not in S0", 0);
    endtask

    task automatic t_sync_hold();
        logic [31:0] v;
        smb_slv_msg = 1;
        @(negedge clk);
        @(negedge clk);
        rd(A_STS, v); chk("R10 not set after two edges", v, 32'h0);
        @(negedge clk);
        rd(A_STS, v); chk("R10 set on third edge", v, 32'h0001_0000);
        chk("R8 SMBus bit without enable no SMI", {31'h0, smi_n}, 32'h1);
        wr(A_STS, 32'h0001_0000);
        rd(A_STS, v); chk("R11 clear inside hold-off ignored", v, 32'h0001_0000);
        idle(HOLD + 2);
        wr(A_STS, 32'h0001_0000);
        rd(A_STS, v); chk("R11 clear after hold-off works", v, 32'h0);
        idle(6);
        rd(A_STS, v); chk("R10 held level sets only once", v, 32'h0);
        smb_clear_all();
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_w1c();
        t_periodic();
        t_set_wins();
        t_nonsticky();
        t_usb();
        t_free();
        t_smb_qual();
        t_sync_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule